// File: doc/BRIEF.md
# Byte-Wide EEPROM Access and Burst Loader

This block sits between a host-side 32-bit register bus and an external byte-wide EEPROM. The host can read or write one EEPROM byte at a time through an address register, a data register and two command bits that hardware clears by itself. The EEPROM side is a request/acknowledge port. A request carries the address, the write flag and the write byte, and it stays up until the device acknowledges. Read data comes back with the acknowledge.

The block can also run a burst load. It reads a count byte N and then N six-byte records. Each record holds a 16-bit little-endian target address followed by four data bytes, and each record turns into one 32-bit write on an internal memory port. The 24-bit memory address joins a host-programmed 9-bit base, which forms the upper part, with the low 15 bits of the record address. Bit 15 of the record address is dropped.

A burst does not always start at address 0. It reads from a pointer that starts at 0 after reset and then moves to the byte after the most recent EEPROM access of any kind. Two bursts in a row therefore read consecutive areas, and a burst started after a single access continues right after that access.

Top module: `eeprom_loader`

## Requirements
- R1: After reset, all registers read as zero, no EEPROM request is raised and no memory write occurs.
- R2: Writing 1 to bit 1 of CTRL (register index 0) reads the EEPROM byte at ADDR (index 1) into DATA (index 2, bits 7:0). The bit clears itself, and DATA is valid once the bit reads 0.
- R3: Writing 1 to bit 0 of CTRL stores DATA bits 7:0 at the EEPROM location in ADDR. The bit clears itself when the device acknowledges.
- R4: A CTRL write with bits 0 and 1 both set performs only the read. The EEPROM contents are left unchanged.
- R5: Bit 2 of CTRL reads 1 while a single access or a burst is pending. While it is 1, host writes to every register are ignored.
- R6: Writing 1 to bit 0 of BURST (index 4) starts a burst. The bit reads 1 while the burst runs and clears itself when the burst ends.
- R7: A burst reads from EEPROM address 0 if nothing was accessed since reset. Otherwise it starts at the address after the last byte accessed, wrapping at the top of the EEPROM address space.
- R8: A burst reads a count byte N, then N records. Each record is address low, address high, then data bytes 0 to 3, with data byte 0 going to bits 7:0. Each record gives exactly one single-cycle memory write. N = 0 gives no write.
- R9: The memory write address is BASE (index 3, bits 8:0) in bits 23:15 and the record address bits 14:0 below it. Record address bit 15 is ignored.
- R10: An EEPROM request keeps its address and write flag stable until acknowledged. Exactly one byte is transferred per acknowledge, so a burst of N records takes 1+6N handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback for reg_addr |
| ee_req | output | 1 | EEPROM request, held until acknowledged |
| ee_we | output | 1 | Request is a write |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | Device acknowledge |
| ee_rdata | input | 8 | Read byte, valid with ee_ack |
| mem_we | output | 1 | Internal memory write strobe |
| mem_addr | output | MEM_AW | Internal memory word address |
| mem_wdata | output | 32 | Internal memory write data |

## Verification
The bench builds the block with a 10-bit EEPROM address, so a burst can be placed across the top of the EEPROM address space. This exercises the pointer wrap back to address 0 in the middle of a record. The 9-bit base and the 24-bit memory address keep their default widths, so a record address with bit 15 set checks that the upper address bits come only from the base. The modelled device answers after a two-cycle delay. This leaves several cycles in which register writes arrive while the block is busy and must be ignored.

// File: rtl/eel_pkg.sv
package eel_pkg;

    localparam int REG_IW = 3;

    localparam logic [REG_IW-1:0] RA_CTRL  = 3'd0;
    localparam logic [REG_IW-1:0] RA_ADDR  = 3'd1;
    localparam logic [REG_IW-1:0] RA_DATA  = 3'd2;
    localparam logic [REG_IW-1:0] RA_BASE  = 3'd3;
    localparam logic [REG_IW-1:0] RA_BURST = 3'd4;

    localparam int REC_BYTES = 6;
    localparam int IDX_W     = $clog2(REC_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_BYTES - 1);

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ONE,
        ENG_CNT,
        ENG_REC
    } eng_state_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } cmd_t;

    // A dual request collapses to a read.
    function automatic cmd_t decode_cmd(input logic [31:0] w);
        cmd_t c;
        c.rd = w[1];
        c.wr = w[0] & ~w[1];
        return c;
    endfunction

endpackage

// File: rtl/eel_regs.sv
module eel_regs
    import eel_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_IW-1:0] idx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              one_done,
    input  logic              rd_load,
    input  logic [7:0]        rd_byte,
    input  logic              burst_done,
    output cmd_t              cmd_q,
    output logic [EE_AW-1:0]  addr_q,
    output logic [7:0]        data_q,
    output logic [BASE_W-1:0] base_q,
    output logic              burst_q,
    output logic              busy
);
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    assign busy = cmd_q.rd | cmd_q.wr | burst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            base_q  <= '0;
            burst_q <= 1'b0;
        end else begin
            if (wr_en && !busy) begin
                case (idx)
                    RA_CTRL:  cmd_q   <= decode_cmd(wdata);
                    RA_ADDR:  addr_q  <= wdata[EE_AW-1:0];
                    RA_DATA:  data_q  <= wdata[7:0];
                    RA_BASE:  base_q  <= wdata[BASE_W-1:0];
                    RA_BURST: burst_q <= wdata[0];
                    default: ;
                endcase
            end
            if (one_done)   cmd_q   <= '0;
            if (rd_load)    data_q  <= rd_byte;
            if (burst_done) burst_q <= 1'b0;
        end
    end

    always_comb begin
        case (idx)
            RA_CTRL:  rdata = {29'd0, busy, cmd_q.rd, cmd_q.wr};
            RA_ADDR:  rdata = 32'(addr_q);
            RA_DATA:  rdata = 32'(data_q);
            RA_BASE:  rdata = 32'(base_q);
            RA_BURST: rdata = 32'(burst_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/eel_engine.sv
module eel_engine
    import eel_pkg::*;
#(
    parameter int EE_AW = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd_q,
    input  logic             burst_q,
    input  logic [EE_AW-1:0] addr_q,
    input  logic [7:0]       data_q,
    output logic             ee_req,
    output logic             ee_we,
    output logic [EE_AW-1:0] ee_addr,
    output logic [7:0]       ee_wdata,
    input  logic             ee_ack,
    input  logic [7:0]       ee_rdata,
    output logic             one_done,
    output logic             rd_load,
    output logic             burst_done,
    output logic             rec_vld,
    output logic [IDX_W-1:0] rec_idx
);
    eng_state_t       state;
    logic             is_wr;
    logic [EE_AW-1:0] ptr;
    logic [CNT_W-1:0] rec_left;
    logic [IDX_W-1:0] idx;
    logic             last_rec;

    assign last_rec = (idx == IDX_LAST) && (rec_left == CNT_W'(1));

    always_comb begin
        ee_req     = (state != ENG_IDLE);
        ee_we      = (state == ENG_ONE) && is_wr;
        ee_addr    = (state == ENG_ONE) ? addr_q : ptr;
        ee_wdata   = data_q;
        one_done   = (state == ENG_ONE) && ee_ack;
        rd_load    = one_done && !is_wr;
        rec_vld    = (state == ENG_REC) && ee_ack;
        rec_idx    = idx;
        burst_done = ee_ack && (((state == ENG_CNT) && (ee_rdata == 8'd0)) ||
                                ((state == ENG_REC) && last_rec));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            is_wr    <= 1'b0;
            ptr      <= '0;
            rec_left <= '0;
            idx      <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (cmd_q.rd || cmd_q.wr) begin
                        state <= ENG_ONE;
                        is_wr <= cmd_q.wr;
                    end else if (burst_q) begin
                        state <= ENG_CNT;
                    end
                end
                ENG_ONE: if (ee_ack) begin
                    state <= ENG_IDLE;
                    ptr   <= EE_AW'(addr_q + 1'b1);
                end
                ENG_CNT: if (ee_ack) begin
                    ptr      <= EE_AW'(ptr + 1'b1);
                    rec_left <= CNT_W'(ee_rdata);
                    idx      <= '0;
                    state    <= (ee_rdata == 8'd0) ? ENG_IDLE : ENG_REC;
                end
                ENG_REC: if (ee_ack) begin
                    ptr <= EE_AW'(ptr + 1'b1);
                    if (idx == IDX_LAST) begin
                        idx      <= '0;
                        rec_left <= CNT_W'(rec_left - 1'b1);
                        if (last_rec) state <= ENG_IDLE;
                    end else begin
                        idx <= IDX_W'(idx + 1'b1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eel_pack.sv
module eel_pack
    import eel_pkg::*;
#(
    parameter int BASE_W = 9,
    parameter int MEM_AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_vld,
    input  logic [IDX_W-1:0]  rec_idx,
    input  logic [7:0]        rec_byte,
    input  logic [BASE_W-1:0] base_q,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata
);
    localparam int LOW_W = MEM_AW - BASE_W;

    logic [7:0]  hold [REC_BYTES-1];
    logic [15:0] rec_word;
    logic        unused_hi;

    for (genvar k = 0; k < REC_BYTES - 1; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)                                   hold[k] <= '0;
            else if (rec_vld && rec_idx == IDX_W'(k))  hold[k] <= rec_byte;
        end
    end

    assign rec_word  = {hold[1], hold[0]};
    assign unused_hi = ^rec_word[15:LOW_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= rec_vld && (rec_idx == IDX_LAST);
            if (rec_vld && rec_idx == IDX_LAST) begin
                mem_addr  <= {base_q, rec_word[LOW_W-1:0]};
                mem_wdata <= {rec_byte, hold[4], hold[3], hold[2]};
            end
        end
    end
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
    import eel_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9,
    parameter int MEM_AW = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    input  logic              ee_ack,
    input  logic [7:0]        ee_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata
);
    cmd_t              cmd_q;
    logic [EE_AW-1:0]  addr_q;
    logic [7:0]        data_q;
    logic [BASE_W-1:0] base_q;
    logic              burst_q, busy;
    logic              one_done, rd_load, burst_done, rec_vld;
    logic [IDX_W-1:0]  rec_idx;

    eel_regs #(.EE_AW(EE_AW), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .idx(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .one_done(one_done), .rd_load(rd_load), .rd_byte(ee_rdata),
        .burst_done(burst_done), .cmd_q(cmd_q), .addr_q(addr_q),
        .data_q(data_q), .base_q(base_q), .burst_q(burst_q), .busy(busy)
    );

    eel_engine #(.EE_AW(EE_AW), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(rst), .cmd_q(cmd_q), .burst_q(burst_q),
        .addr_q(addr_q), .data_q(data_q),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
        .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .one_done(one_done), .rd_load(rd_load), .burst_done(burst_done),
        .rec_vld(rec_vld), .rec_idx(rec_idx)
    );

    eel_pack #(.BASE_W(BASE_W), .MEM_AW(MEM_AW)) u_pack (
        .clk(clk), .rst(rst), .rec_vld(rec_vld), .rec_idx(rec_idx),
        .rec_byte(ee_rdata), .base_q(base_q),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/eel_chk.sv
module eel_chk #(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9,
    parameter int MEM_AW = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              ee_req,
    input logic              ee_ack,
    input logic              ee_we,
    input logic [EE_AW-1:0]  ee_addr,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [BASE_W-1:0] base_q,
    input logic              burst_q,
    input logic              busy,
    input logic              cmd_rd,
    input logic              cmd_wr
);
    logic unused_lo;
    assign unused_lo = ^mem_addr[MEM_AW-BASE_W-1:0];

    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        ee_req && !ee_ack |=> ee_req);

    a_r10_req_stable: assert property (@(posedge clk) disable iff (rst)
        ee_req && !ee_ack |=> $stable(ee_addr) && $stable(ee_we));

    a_r8_write_from_burst: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(burst_q));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r9_base_bits: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[MEM_AW-1 -: BASE_W] == base_q);

    a_r4_no_dual_cmd: assert property (@(posedge clk) disable iff (rst)
        !(cmd_rd && cmd_wr));

    a_r5_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        ee_req |-> busy);
endmodule

bind eeprom_loader eel_chk #(.EE_AW(EE_AW), .BASE_W(BASE_W), .MEM_AW(MEM_AW)) u_chk (
    .clk(clk), .rst(rst), .ee_req(ee_req), .ee_ack(ee_ack), .ee_we(ee_we),
    .ee_addr(ee_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .base_q(base_q), .burst_q(burst_q), .busy(busy),
    .cmd_rd(cmd_q.rd), .cmd_wr(cmd_q.wr)
);

// File: tb/tb_eeprom_loader.sv
module tb_eeprom_loader;
    localparam int CLK_PERIOD = 10;
    localparam int EE_AW  = 10;
    localparam int BASE_W = 9;
    localparam int MEM_AW = 24;
    localparam int LAT    = 2;
    localparam int EE_SZ  = 1 << EE_AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              ee_req, ee_we;
    logic [EE_AW-1:0]  ee_addr;
    logic [7:0]        ee_wdata;
    logic              ee_ack = 1'b0;
    logic [7:0]        ee_rdata = '0;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [31:0]       mem_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    int lat_cnt = 0;
    int n_ack   = 0;
    logic [7:0]  ee_mem [EE_SZ];
    logic [55:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_loader #(.EE_AW(EE_AW), .BASE_W(BASE_W), .MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Device model: acknowledges after LAT cycles of a pending request.
    always @(negedge clk) begin
        if (ee_ack) begin
            ee_ack  = 1'b0;
            lat_cnt = 0;
        end else if (!rst && ee_req) begin
            lat_cnt++;
            if (lat_cnt >= LAT) begin
                ee_ack   = 1'b1;
                n_ack++;
                ee_rdata = ee_mem[ee_addr];
                if (ee_we) ee_mem[ee_addr] = ee_wdata;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    // Memory-side reference: each strobe must match the next expected record.
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected memory write", 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
                logic [55:0] e;
                e = exp_q.pop_front();
                chk("R9 memory address", 32'(mem_addr), 32'(e[55:32]));
                chk("R8 memory data", mem_wdata, e[31:0]);
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            reg_read(3'd0, v);
            if (v[2] == 1'b0) break;
        end
    endtask

    // Lays a burst image into the device and queues the writes it implies.
    task automatic put_burst(input int start, input int n, input logic [8:0] base, input int seed);
        int p;
        p = start;
        ee_mem[p % EE_SZ] = 8'(n); p++;
        for (int r = 0; r < n; r++) begin
            logic [15:0] ra;
            logic [31:0] d;
            ra = 16'(16'h8123 + seed * 16'h0351 + r * 16'h4107);
            d  = 32'(32'hA1B2_C3D4 ^ (seed * 32'h0101_0101) ^ (r * 32'h1357_9BDF));
            ee_mem[p % EE_SZ] = ra[7:0];  p++;
            ee_mem[p % EE_SZ] = ra[15:8]; p++;
            for (int b = 0; b < 4; b++) begin
                ee_mem[p % EE_SZ] = d[8*b +: 8]; p++;
            end
            exp_q.push_back({base, ra[14:0], d});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < EE_SZ; i++) ee_mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), v);
            chk("R1 register reset value", v, 32'd0);
        end
        chk("R1 no request after reset", 32'(ee_req), 32'd0);
        chk("R1 no memory write after reset", 32'(mem_we), 32'd0);

        // R7 fresh burst from address 0, R9 with bit 15 of record address set
        reg_write(3'd3, 32'h1A5);
        put_burst(0, 2, 9'h1A5, 1);
        n_ack = 0;
        reg_write(3'd4, 32'h1);
        reg_read(3'd4, v);
        chk("R6 burst bit set while running", v, 32'd1);
        reg_read(3'd0, v);
        chk("R5 busy during burst", 32'(v[2]), 32'd1);
        wait_idle();
        reg_read(3'd4, v);
        chk("R6 burst bit self-clears", v, 32'd0);
        chk("R7 fresh burst consumed from address 0", 32'(exp_q.size()), 32'd0);
        chk("R10 handshakes per burst", 32'(n_ack), 32'd13);

        // R2 single read; R5 address write while busy is ignored
        ee_mem[100] = 8'h5A;
        reg_write(3'd1, 32'd100);
        reg_write(3'd0, 32'h2);
        reg_write(3'd1, 32'd5);
        wait_idle();
        reg_read(3'd2, v);
        chk("R2 read data", v, 32'h5A);
        reg_read(3'd0, v);
        chk("R2 read bit self-clears", v, 32'd0);
        reg_read(3'd1, v);
        chk("R5 address write ignored while busy", v, 32'd100);

        // R3 single write
        reg_write(3'd1, 32'd200);
        reg_write(3'd2, 32'h3C);
        reg_write(3'd0, 32'h1);
        wait_idle();
        chk("R3 byte stored", 32'(ee_mem[200]), 32'h3C);
        reg_read(3'd0, v);
        chk("R3 write bit self-clears", v, 32'd0);

        // R4 dual request is a read
        ee_mem[300] = 8'h11;
        reg_write(3'd1, 32'd300);
        reg_write(3'd2, 32'h77);
        reg_write(3'd0, 32'h3);
        wait_idle();
        reg_read(3'd2, v);
        chk("R4 dual request reads", v, 32'h11);
        chk("R4 dual request leaves device", 32'(ee_mem[300]), 32'h11);

        // R7 burst continues after last single access; R5 writes ignored mid-burst
        reg_write(3'd3, 32'h003);
        put_burst(301, 1, 9'h003, 2);
        reg_write(3'd4, 32'h1);
        reg_write(3'd0, 32'h2);
        reg_write(3'd3, 32'h0FF);
        wait_idle();
        chk("R7 burst resumed after single access", 32'(exp_q.size()), 32'd0);
        reg_read(3'd2, v);
        chk("R5 control write ignored during burst", v, 32'h11);
        reg_read(3'd3, v);
        chk("R5 base write ignored during burst", v, 32'h003);

        // R8 empty burst continues after previous burst
        ee_mem[308] = 8'd0;
        n_ack = 0;
        reg_write(3'd4, 32'h1);
        wait_idle();
        reg_read(3'd4, v);
        chk("R8 empty burst ends", v, 32'd0);
        chk("R8 empty burst single handshake", 32'(n_ack), 32'd1);

        // R7 wrap of the burst pointer at the top of the address space
        reg_write(3'd1, 32'(EE_SZ - 4));
        reg_write(3'd0, 32'h2);
        wait_idle();
        put_burst(EE_SZ - 3, 1, 9'h003, 3);
        reg_write(3'd4, 32'h1);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R7 burst wraps address space", 32'(exp_q.size()), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule